// File: doc/BRIEF.md
# Table-Driven Synchronous State Sequencer

This block is a small Moore-style state machine. Its whole next-state and output behaviour comes from one lookup table held in a parameter. A two-bit event input is first captured in a register on the system clock. The captured inputs and the two-bit present state together address a sixteen-entry table. Each five-bit entry names the state to enter and the three-bit output that goes with that state.

The state and the output are both loaded from the same table word on the same clock edge. Because the inputs are registered beside the state, every transition is aligned to the clock, and an input change reaches the outputs a fixed number of edges later. A different machine is obtained by passing a different table parameter; the structure does not change.

The event input and the outputs are plain level signals sampled or updated every clock. There is no valid/ready handshake and no back-pressure: the table is consulted on every edge.

Top module: `table_seq`

## Requirements
- R1: `ev_in` is captured into an input register on every rising clock edge. A value present before edge k changes `state_o` and `out_o` only at edge k+1, never at edge k.
- R2: The table address is {present state, registered inputs}: the state occupies address bits [3:2] and the registered inputs occupy bits [1:0].
- R3: In a table word, bits [4:3] are the next state and bits [2:0] are the output. Both are loaded into `state_o` and `out_o` on the same edge.
- R4: The default table, from address 0 to 15, is 1E,07,07,0B, 0B,1E,07,15, 15,0B,15,15, 1E,15,1E,1E (hex).
- R5: While `rst` is high at a rising edge, the state register, the input register and `out_o` are all cleared to zero on that edge (synchronous reset).
- R6: The table is a module parameter packed with entry i at bits [5i+4:5i]. Any contents give a machine that follows that table, with no change to the RTL.
- R7: When the addressed word names the present state as its next state, the state is held. With the default table this happens, for example, in state 0 with registered inputs 1 or 2, and in state 2 with registered inputs 0, 2 or 3.
- R8: With the default table the output depends only on the state entered: state 0 gives 7, state 1 gives 3, state 2 gives 5 and state 3 gives 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | 2 | Event inputs, captured every clock |
| state_o | output | 2 | Present state register |
| out_o | output | 3 | Registered output field of the last table word |

## Verification
An input driven before edge k is in the input register after edge k. Its effect on `state_o` and `out_o` is due after edge k+1. `out_o` and `state_o` change on the same edge. The bench drives the inputs on the falling edge and samples the outputs on the next falling edge. It keeps a model of the input register and of the state, so each comparison lines up with the two-edge path. Long sweeps of input patterns run through the default table and through a second, arithmetically generated table. Reset is applied in the middle of a sweep and checked half a cycle after the edge that samples it.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned ST_W   = 2;
  localparam int unsigned EV_W   = 2;
  localparam int unsigned OUT_W  = 3;
  localparam int unsigned ADDR_W = ST_W + EV_W;
  localparam int unsigned WORD_W = ST_W + OUT_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  // Entry i sits at bits [i*WORD_W +: WORD_W]; listed from entry 15 down to 0.
  localparam logic [DEPTH*WORD_W-1:0] DEFAULT_TABLE = {
    5'h1E, 5'h1E, 5'h15, 5'h1E,
    5'h15, 5'h15, 5'h0B, 5'h15,
    5'h15, 5'h07, 5'h1E, 5'h0B,
    5'h0B, 5'h07, 5'h07, 5'h1E
  };
endpackage

// File: rtl/seq_in_reg.sv
module seq_in_reg #(
  parameter int unsigned EV_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EV_W-1:0] din,
  output logic [EV_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= din;
  end

  // R1
  in_capture_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q == $past(din));
endmodule

// File: rtl/seq_table_rom.sv
module seq_table_rom #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 5,
  parameter int unsigned DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] TABLE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = TABLE[g*WORD_W +: WORD_W];
  end

  assign word = rom[addr];
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg #(
  parameter int unsigned ST_W  = 2,
  parameter int unsigned OUT_W = 3,
  localparam int unsigned WORD_W = ST_W + OUT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] next_word,
  output logic [ST_W-1:0]   state_q,
  output logic [OUT_W-1:0]  out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      out_q   <= '0;
    end else begin
      state_q <= next_word[WORD_W-1 -: ST_W];
      out_q   <= next_word[OUT_W-1:0];
    end
  end

  // R5
  state_clear_chk: assert property (@(posedge clk)
    rst |=> state_q == '0);

  // R5
  out_clear_chk: assert property (@(posedge clk)
    rst |=> out_q == '0);
endmodule

// File: rtl/table_seq.sv
module table_seq
  import seq_pkg::*;
#(
  parameter logic [DEPTH*WORD_W-1:0] TABLE = DEFAULT_TABLE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EV_W-1:0]  ev_in,
  output logic [ST_W-1:0]  state_o,
  output logic [OUT_W-1:0] out_o
);
  logic [EV_W-1:0]   ev_q;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word;

  seq_in_reg #(.EV_W(EV_W)) u_in (
    .clk (clk),
    .rst (rst),
    .din (ev_in),
    .q   (ev_q)
  );

  // R2: state in the upper address bits, registered inputs in the lower.
  assign addr = {state_o, ev_q};

  seq_table_rom #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .TABLE  (TABLE)
  ) u_rom (
    .addr (addr),
    .word (word)
  );

  seq_state_reg #(.ST_W(ST_W), .OUT_W(OUT_W)) u_st (
    .clk       (clk),
    .rst       (rst),
    .next_word (word),
    .state_q   (state_o),
    .out_q     (out_o)
  );

  // Independent slice of the parameter for the checker below.
  logic [WORD_W-1:0] ref_word;
  always_comb begin
    ref_word = TABLE[int'({state_o, ev_q})*WORD_W +: WORD_W];
  end

  // R3 R6
  table_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> {state_o, out_o} == $past(ref_word));

  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_word[WORD_W-1 -: ST_W] == state_o) |=> $stable(state_o));
endmodule

// File: tb/tb_table_seq.sv
module tb_table_seq;
  localparam int CLK_PERIOD = 10;

  function automatic logic [79:0] gen_table();
    logic [79:0] t;
    t = '0;
    for (int a = 0; a < 16; a++) begin
      t[a*5 +: 5] = {2'((a + 1) & 3), 3'((a ^ 5) & 7)};
    end
    return t;
  endfunction
  localparam logic [79:0] ALT_TABLE = gen_table();

  logic       clk = 0;
  logic       rst = 1;
  logic [1:0] ev  = 0;
  logic [1:0] st_a, st_b;
  logic [2:0] out_a, out_b;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int m_in, m_st_a, m_out_a, m_st_b, m_out_b;

  table_seq dut (.clk(clk), .rst(rst), .ev_in(ev), .state_o(st_a), .out_o(out_a));
  table_seq #(.TABLE(ALT_TABLE)) dut_alt (.clk(clk), .rst(rst), .ev_in(ev),
                                          .state_o(st_b), .out_o(out_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Default contents, computed from the listed hex words.
  function automatic int dflt_word(int a);
    int w[16] = '{'h1E,'h07,'h07,'h0B,'h0B,'h1E,'h07,'h15,
                  'h15,'h0B,'h15,'h15,'h1E,'h15,'h1E,'h1E};
    return w[a];
  endfunction

  function automatic int alt_word(int a);
    return (((a + 1) & 3) << 3) | ((a ^ 5) & 7);
  endfunction

  function automatic int state_out(int s);
    int m[4] = '{7, 3, 5, 6};
    return m[s];
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive v, advance one edge, compare at next falling edge.
  task automatic step(int v);
    int w, prev;
    ev = 2'(v);
    @(posedge clk);
    prev    = m_st_a;
    w       = dflt_word(m_st_a * 4 + m_in);
    m_st_a  = w >> 3;
    m_out_a = w & 7;
    w       = alt_word(m_st_b * 4 + m_in);
    m_st_b  = w >> 3;
    m_out_b = w & 7;
    m_in    = v;
    @(negedge clk);
    if (prev == m_st_a) check("R7 hold state", int'(st_a), m_st_a);
    else                check("R1 R2 R4 next state", int'(st_a), m_st_a);
    check("R3 output field", int'(out_a), m_out_a);
    check("R8 output per state", int'(out_a), state_out(int'(st_a)));
    check("R6 alt table state", int'(st_b), m_st_b);
    check("R6 alt table output", int'(out_b), m_out_b);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    check("R5 reset state", int'(st_a), 0);
    check("R5 reset output", int'(out_a), 0);
    check("R5 reset alt state", int'(st_b), 0);
    rst = 0;
    m_in = 0; m_st_a = 0; m_out_a = 0; m_st_b = 0; m_out_b = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R1: new input reaches the state only on the second edge.
    ev = 2'd1;
    @(posedge clk);
    @(negedge clk);
    check("R1 first edge uses old input", int'(st_a), 3);
    m_st_a = 3; m_out_a = 6; m_st_b = 1; m_out_b = 5; m_in = 1;
    step(1);
    check("R1 second edge uses new input", int'(st_a), 2);

    // Near-exhaustive sweeps over every state/input pair.
    for (int i = 0; i < 400; i++) step((i * 7 + i / 5 + i / 17) & 3);
    do_reset();
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) step(s);
      for (int v = 0; v < 4; v++) step(v);
    end
    for (int i = 0; i < 200; i++) step((i ^ (i >> 2)) & 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule